// File: doc/BRIEF.md
# Selectable-Clock Input Glitch Filter

This block removes short glitches from groups of asynchronous digital inputs before they reach the rest of the chip. The inputs are split into twelve groups. Groups 0 to 7 are general port groups. Groups 8 to 11 are dedicated inputs: reset/IRQ (8), keyboard-interrupt group A (9), keyboard-interrupt group B (10) and the non-maskable interrupt (11). Each group has `LANES` input bits. Each raw bit first passes through a two-flop synchronizer. It then reaches a small per-bit state machine. That machine only moves its output to a new level after two consecutive samples of the group's sampling strobe agree on that level.

Each group picks its sampling strobe with its own 2-bit select code. Code 0 samples on every bus-clock cycle for the port groups; for the dedicated groups, code 0 bypasses the filter. Codes 1, 2 and 3 pick one of three shared divided strobes, and each divided strobe has its own threshold field. Strobe 1 counts pulses of `lpo_tick`, the low-power oscillator clock brought in as a one-cycle enable that is already synchronized to the bus clock. Strobes 2 and 3 divide the bus clock. All counters run on the bus clock. The configuration is one 32-bit word. Software changes a single field by reading the word, changing that field and writing the word back.

Each lane's state machine has two states. HOLD means the synchronized input agrees with the output. PEND means one sample has seen a different level. The transitions on a sampling strobe are:
- HOLD->PEND, called "suspect": the sample differs from the output.
- PEND->HOLD, called "confirm": the sample still differs, so the output takes the new level.
- PEND->HOLD, called "reject": the sample matches the output again.

Outside a strobe the state does not change. While the block is settling after reset, or while the group is bypassed, the machine is forced into HOLD and the output follows the synchronized input. This forced move is the "load" transition.

Top module: `pin_glitch_filter`

## Requirements
- R1: After reset the configuration word reads 0. Three cycles after reset release, and from then on, each output equals the level its raw input has held since before the release.
- R2: The configuration word is laid out as follows:
  - Group g's select code sits at bits [2g+1:2g].
  - Threshold 1 sits at [26:24], threshold 2 at [29:27] and threshold 3 at [31:30].
  - A write replaces the whole word, and the word reads back unchanged.
  - A read-modify-write of one field leaves every other field unchanged.
- R3: With select code 0, a port-group output takes a new, steady input level at the fourth rising edge after the input change. It still shows the old level after the third edge.
- R4: A filtered input pulse that covers fewer than two sampling strobes never reaches the output. With code 0 on a port group, a one-cycle pulse is removed and a two-cycle pulse passes.
- R5: With select code 0, a dedicated group (8 to 11) is not filtered. Its output takes the new level at the third rising edge after the input change, and a one-cycle pulse passes.
- R6: Select code 1 samples on every 2^n-th `lpo_tick`, where n is threshold 1 (0 to 7). The strobe never fires in a cycle without `lpo_tick`.
- R7: Select code 2 samples once every 2^(n+5) bus cycles, where n is threshold 2 (0 to 7).
- R8: Select code 3 samples once every 2^(n+1) bus cycles, where n is threshold 3 (0 to 3).
- R9: Each group uses its own select code. Two groups that see the same pulse at the same time with different codes filter it differently. A filtered output changes only on a strobe of its selected set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| cfg_we | input | 1 | Writes `cfg_wdata` into the configuration word |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Current configuration word |
| lpo_tick | input | 1 | One-cycle enable per low-power oscillator period, synchronous to clk |
| raw_in | input | 24 | Raw asynchronous inputs, group g in bits [2g+1:2g] |
| filt_out | output | 24 | Filtered outputs, same bit order as `raw_in` |

## Verification
The bench times a single-bit change on a port group against a dedicated group, both at code 0. A design that bypassed the ports or filtered the dedicated inputs would be off by one edge. It sends pulses just shorter and just longer than two strobe periods on each divided set, at two threshold values each. A divider that ignores its threshold, or uses the wrong exponent base, would let through a pulse that should be removed, or remove one that should pass. It also drives one pulse into two groups at once with different codes, and writes single fields by read-modify-write, so that a select code shared between groups or a corrupted neighbouring field shows up.

// File: rtl/gf_pkg.sv
package gf_pkg;
    localparam int SEL_W     = 2;
    localparam int T1_W      = 3;
    localparam int T2_W      = 3;
    localparam int T3_W      = 2;
    localparam int T2_BASE   = 5;
    localparam int T3_BASE   = 1;
    localparam int LPO_CNT_W = (1 << T1_W) - 1;
    localparam int BUS_CNT_W2 = (1 << T2_W) - 1 + T2_BASE;
    localparam int BUS_CNT_W3 = (1 << T3_W) - 1 + T3_BASE;
    localparam int BUS_CNT_W = (BUS_CNT_W2 > BUS_CNT_W3) ? BUS_CNT_W2 : BUS_CNT_W3;

    localparam logic [SEL_W-1:0] SEL_DIRECT = 2'd0;
    localparam logic [SEL_W-1:0] SEL_SET1   = 2'd1;
    localparam logic [SEL_W-1:0] SEL_SET2   = 2'd2;
    localparam logic [SEL_W-1:0] SEL_SET3   = 2'd3;

    typedef enum logic {
        GF_HOLD = 1'b0,
        GF_PEND = 1'b1
    } gf_state_e;
endpackage

// File: rtl/gf_tick_gen.sv
module gf_tick_gen
    import gf_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lpo_tick,
    input  logic [T1_W-1:0] thr1,
    input  logic [T2_W-1:0] thr2,
    input  logic [T3_W-1:0] thr3,
    output logic            en1,
    output logic            en2,
    output logic            en3
);
    logic [LPO_CNT_W-1:0] lpo_cnt_q;
    logic [BUS_CNT_W-1:0] bus_cnt_q;
    logic [LPO_CNT_W:0]   one_sh1, full1;
    logic [BUS_CNT_W:0]   one_sh2, one_sh3, full2, full3;
    logic [LPO_CNT_W-1:0] mask1;
    logic [BUS_CNT_W-1:0] mask2, mask3;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lpo_cnt_q <= '0;
            bus_cnt_q <= '0;
        end else begin
            bus_cnt_q <= bus_cnt_q + 1'b1;
            if (lpo_tick) lpo_cnt_q <= lpo_cnt_q + 1'b1;
        end
    end

    // Low-order all-ones masks: a strobe fires when the counter's low bits wrap.
    always_comb begin
        one_sh1 = {{LPO_CNT_W{1'b0}}, 1'b1} << int'(thr1);
        one_sh2 = {{BUS_CNT_W{1'b0}}, 1'b1} << (int'(thr2) + T2_BASE);
        one_sh3 = {{BUS_CNT_W{1'b0}}, 1'b1} << (int'(thr3) + T3_BASE);
        full1   = one_sh1 - {{LPO_CNT_W{1'b0}}, 1'b1};
        full2   = one_sh2 - {{BUS_CNT_W{1'b0}}, 1'b1};
        full3   = one_sh3 - {{BUS_CNT_W{1'b0}}, 1'b1};
        mask1   = full1[LPO_CNT_W-1:0];
        mask2   = full2[BUS_CNT_W-1:0];
        mask3   = full3[BUS_CNT_W-1:0];
        en1     = lpo_tick && ((lpo_cnt_q & mask1) == mask1);
        en2     = (bus_cnt_q & mask2) == mask2;
        en3     = (bus_cnt_q & mask3) == mask3;
    end
endmodule

// File: rtl/gf_lane.sv
module gf_lane
    import gf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic bypass,
    input  logic samp_en,
    input  logic din,
    output logic dout
);
    gf_state_e state_q, state_d;
    logic      differs;

    assign differs = din != dout;

    always_comb begin
        state_d = state_q;
        if (load || bypass) begin
            state_d = GF_HOLD;
        end else if (samp_en) begin
            unique case (state_q)
                GF_HOLD: state_d = differs ? GF_PEND : GF_HOLD;
                GF_PEND: state_d = GF_HOLD;
                default: state_d = GF_HOLD;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GF_HOLD;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout <= 1'b0;
        end else if (load || bypass) begin
            dout <= din;
        end else if (samp_en && state_q == GF_PEND && differs) begin
            dout <= din;
        end
    end
endmodule

// File: rtl/pin_glitch_filter.sv
module pin_glitch_filter
    import gf_pkg::*;
#(
    parameter  int NUM_PORT_GRP = 8,
    parameter  int NUM_DED_GRP  = 4,
    parameter  int LANES        = 2,
    localparam int NUM_GRP      = NUM_PORT_GRP + NUM_DED_GRP,
    localparam int NIN          = NUM_GRP * LANES,
    localparam int T1_LSB       = SEL_W * NUM_GRP,
    localparam int T2_LSB       = T1_LSB + T1_W,
    localparam int T3_LSB       = T2_LSB + T2_W,
    localparam int CFG_W        = T3_LSB + T3_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    input  logic             lpo_tick,
    input  logic [NIN-1:0]   raw_in,
    output logic [NIN-1:0]   filt_out
);
    logic [CFG_W-1:0]   cfg_q;
    logic [NIN-1:0]     sync_q1, sync_q2;
    logic [1:0]         init_q;
    logic               load;
    logic               en1, en2, en3;
    logic [NUM_GRP-1:0] grp_en, grp_bypass;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_we) cfg_q <= cfg_wdata;
    end
    assign cfg_rdata = cfg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q1 <= '0;
            sync_q2 <= '0;
        end else begin
            sync_q1 <= raw_in;
            sync_q2 <= sync_q1;
        end
    end

    // Outputs load the synchronized level until the synchronizer holds real data.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              init_q <= 2'd0;
        else if (init_q != 2'd3) init_q <= init_q + 2'd1;
    end
    assign load = init_q != 2'd3;

    gf_tick_gen u_ticks (
        .clk      (clk),
        .rst_n    (rst_n),
        .lpo_tick (lpo_tick),
        .thr1     (cfg_q[T1_LSB +: T1_W]),
        .thr2     (cfg_q[T2_LSB +: T2_W]),
        .thr3     (cfg_q[T3_LSB +: T3_W]),
        .en1      (en1),
        .en2      (en2),
        .en3      (en3)
    );

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        localparam bit IS_DED = (g >= NUM_PORT_GRP);
        logic [SEL_W-1:0] sel;
        assign sel = cfg_q[g*SEL_W +: SEL_W];

        always_comb begin
            unique case (sel)
                SEL_DIRECT: grp_en[g] = 1'b1;
                SEL_SET1:   grp_en[g] = en1;
                SEL_SET2:   grp_en[g] = en2;
                SEL_SET3:   grp_en[g] = en3;
                default:    grp_en[g] = 1'b1;
            endcase
        end
        assign grp_bypass[g] = IS_DED && (sel == SEL_DIRECT);

        for (genvar l = 0; l < LANES; l++) begin : g_lane
            gf_lane u_lane (
                .clk     (clk),
                .rst_n   (rst_n),
                .load    (load),
                .bypass  (grp_bypass[g]),
                .samp_en (grp_en[g]),
                .din     (sync_q2[g*LANES+l]),
                .dout    (filt_out[g*LANES+l])
            );
        end
    end
endmodule

// File: rtl/pin_glitch_filter_chk.sv
module pin_glitch_filter_chk #(
    parameter int NUM_GRP = 12,
    parameter int LANES   = 2,
    parameter int CFG_W   = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_we,
    input logic [CFG_W-1:0]   cfg_wdata,
    input logic [CFG_W-1:0]   cfg_rdata,
    input logic               lpo_tick,
    input logic               load,
    input logic               en1,
    input logic               en2,
    input logic               en3,
    input logic [NUM_GRP-1:0] grp_en,
    input logic [NUM_GRP-1:0] grp_bypass,
    input logic [NUM_GRP*LANES-1:0] sync_q2,
    input logic [NUM_GRP*LANES-1:0] filt_out
);
    assert_cfg_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> cfg_rdata == $past(cfg_wdata));

    assert_set1_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        en1 |-> lpo_tick);

    assert_set2_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
        en2 |=> !en2);

    assert_set3_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
        en3 |=> !en3);

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            localparam int B = g * LANES + l;
            assert_hold_off_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
                (!load && !grp_bypass[g] && !grp_en[g]) |=> $stable(filt_out[B]));
            assert_bypass_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (!load && grp_bypass[g]) |=> filt_out[B] == $past(sync_q2[B]));
        end
    end
endmodule

bind pin_glitch_filter pin_glitch_filter_chk #(
    .NUM_GRP (NUM_GRP),
    .LANES   (LANES),
    .CFG_W   (CFG_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .lpo_tick   (lpo_tick),
    .load       (load),
    .en1        (en1),
    .en2        (en2),
    .en3        (en3),
    .grp_en     (grp_en),
    .grp_bypass (grp_bypass),
    .sync_q2    (sync_q2),
    .filt_out   (filt_out)
);

// File: tb/tb_pin_glitch_filter.sv
module tb_pin_glitch_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        lpo_tick = 1'b0;
    logic [23:0] raw_in = '0;
    logic [23:0] filt_out;
    logic [31:0] model = '0;
    int total = 0;
    int bad = 0;
    bit lpo_run = 1'b0;

    always #2 clk = ~clk;

    pin_glitch_filter dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .lpo_tick(lpo_tick), .raw_in(raw_in), .filt_out(filt_out)
    );

    // Low-power clock enable: one pulse every 4 bus cycles.
    initial begin
        int k = 0;
        forever begin
            @(negedge clk);
            if (lpo_run) begin
                lpo_tick = (k % 4 == 0);
                k++;
            end else begin
                lpo_tick = 1'b0;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_field(input int lsb, input int w, input int val);
        logic [31:0] m, cur;
        @(negedge clk);
        cur = cfg_rdata;
        m = ((32'd1 << w) - 32'd1) << lsb;
        cfg_wdata = (cur & ~m) | ((32'(val) << lsb) & m);
        model = (model & ~m) | ((32'(val) << lsb) & m);
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_watch(input int bitn, input int len, input int win, output bit seen);
        seen = 1'b0;
        @(negedge clk);
        raw_in[bitn] = 1'b1;
        for (int c = 0; c < len + win; c++) begin
            @(negedge clk);
            if (filt_out[bitn]) seen = 1'b1;
            if (c == len - 1) raw_in[bitn] = 1'b0;
        end
    endtask

    task automatic t_reset();
        raw_in = 24'hA5C396;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(cfg_rdata == 32'd0, "R1 cfg after reset", cfg_rdata, 0);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(filt_out == 24'hA5C396, "R1 outputs settle", filt_out, 24'hA5C396);
        raw_in = '0;
        repeat (10) @(negedge clk);
        chk(filt_out == 24'h0, "R1 outputs follow low", filt_out, 0);
    endtask

    task automatic t_direct_timing();
        @(negedge clk);
        raw_in[0] = 1'b1;
        raw_in[16] = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(filt_out[16] == 1'b0, "R5 bypass before edge 3", filt_out[16], 0);
        @(posedge clk); @(negedge clk);
        chk(filt_out[16] == 1'b1, "R5 bypass at edge 3", filt_out[16], 1);
        chk(filt_out[0] == 1'b0, "R3 port before edge 4", filt_out[0], 0);
        @(posedge clk); @(negedge clk);
        chk(filt_out[0] == 1'b1, "R3 port at edge 4", filt_out[0], 1);
        raw_in[0] = 1'b0;
        raw_in[16] = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic t_direct_pulses();
        bit s;
        pulse_watch(0, 1, 10, s);
        chk(s == 1'b0, "R4 one-cycle pulse removed on port", s, 0);
        pulse_watch(0, 2, 10, s);
        chk(s == 1'b1, "R4 two-cycle pulse kept on port", s, 1);
        pulse_watch(17, 1, 10, s);
        chk(s == 1'b1, "R5 one-cycle pulse passes bypass", s, 1);
    endtask

    task automatic t_fields();
        set_field(6, 2, 2);            // group 3 select = set 2
        chk(cfg_rdata == model, "R2 group 3 field", cfg_rdata, model);
        set_field(24, 3, 5);           // threshold 1
        set_field(27, 3, 6);           // threshold 2
        set_field(30, 2, 3);           // threshold 3
        set_field(22, 2, 1);           // group 11 select
        chk(cfg_rdata == 32'hF540_0080, "R2 fields isolated", cfg_rdata, 32'hF540_0080);
        set_field(6, 2, 0);
        set_field(22, 2, 0);
        chk(cfg_rdata == 32'hF500_0000, "R2 clear selects only", cfg_rdata, 32'hF500_0000);
    endtask

    task automatic t_set3();
        bit s;
        set_field(10, 2, 3);           // group 5 (bit 10) on set 3
        set_field(30, 2, 0);           // div 2
        pulse_watch(10, 1, 12, s);
        chk(s == 1'b0, "R8 div2 one-cycle removed", s, 0);
        pulse_watch(10, 5, 12, s);
        chk(s == 1'b1, "R8 div2 five-cycle kept", s, 1);
        set_field(30, 2, 3);           // div 16
        pulse_watch(10, 10, 50, s);
        chk(s == 1'b0, "R8 div16 ten-cycle removed", s, 0);
        pulse_watch(10, 40, 50, s);
        chk(s == 1'b1, "R8 div16 forty-cycle kept", s, 1);
        chk(filt_out[10] == 1'b0, "R8 div16 returns low", filt_out[10], 0);
    endtask

    task automatic t_set2();
        bit s;
        set_field(12, 2, 2);           // group 6 (bit 12) on set 2
        set_field(27, 3, 0);           // div 32
        pulse_watch(12, 20, 80, s);
        chk(s == 1'b0, "R7 div32 twenty-cycle removed", s, 0);
        pulse_watch(12, 70, 80, s);
        chk(s == 1'b1, "R7 div32 seventy-cycle kept", s, 1);
        set_field(27, 3, 7);           // div 4096
        pulse_watch(12, 3000, 200, s);
        chk(s == 1'b0, "R7 div4096 long pulse removed", s, 0);
        set_field(27, 3, 0);
    endtask

    task automatic t_set1();
        bit s;
        lpo_run = 1'b1;
        set_field(14, 2, 1);           // group 7 (bit 14) on set 1
        set_field(24, 3, 2);           // every 4th tick -> 16 cycles
        pulse_watch(14, 12, 50, s);
        chk(s == 1'b0, "R6 lpo/4 twelve-cycle removed", s, 0);
        set_field(24, 3, 0);           // every tick -> 4 cycles
        pulse_watch(14, 12, 30, s);
        chk(s == 1'b1, "R6 lpo/1 twelve-cycle kept", s, 1);
        lpo_run = 1'b0;
        repeat (4) @(negedge clk);
        raw_in[14] = 1'b1;
        repeat (60) @(negedge clk);
        chk(filt_out[14] == 1'b0, "R6 no ticks no change", filt_out[14], 0);
        raw_in[14] = 1'b0;
    endtask

    task automatic t_independent();
        bit s5, s6;
        set_field(30, 2, 0);           // group 5 set 3 div 2; group 6 set 2 div 32
        @(negedge clk);
        raw_in[10] = 1'b1;
        raw_in[12] = 1'b1;
        s5 = 1'b0; s6 = 1'b0;
        for (int c = 0; c < 60; c++) begin
            @(negedge clk);
            if (filt_out[10]) s5 = 1'b1;
            if (filt_out[12]) s6 = 1'b1;
            if (c == 9) begin
                raw_in[10] = 1'b0;
                raw_in[12] = 1'b0;
            end
        end
        chk(s5 == 1'b1, "R9 group 5 on set 3 keeps pulse", s5, 1);
        chk(s6 == 1'b0, "R9 group 6 on set 2 removes pulse", s6, 0);
    endtask

    initial begin
        #2000000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_direct_timing();
        t_direct_pulses();
        t_fields();
        t_set3();
        t_set2();
        t_set1();
        t_independent();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule